// File: doc/BRIEF.md
# External Memory Bus Interface

This block sits between an 8-bit microcontroller core and off-chip program and data memory. Every cycle the core may present one request: a code fetch, a data read, a data write or an internal data access, together with a 16-bit address and, for writes, a byte of write data. The block registers the request and turns it into one access cycle on the external pins. It drives the address bus, raises one of three active-low strobes (program store, data read, data write) and either drives or releases the bidirectional data bus. At the clock edge that closes the cycle it captures the bus byte for reads and fetches and hands it back to the core with a one-cycle valid pulse.

Whether a code fetch goes off chip depends on an external-access select pin. With the pin low, the low 8 KiB of code space is served on chip and only fetches from 0x2000 upward assert the program strobe. With the pin high, every code fetch goes off chip. The address bus always shows the most recently accepted address, including internal accesses. While the suspend input is high, the data bus is driven to all zeros instead of floating, and new requests are ignored.

Top module: `emb_bus_if`

## Requirements
- R1: After reset the three strobes are high, the data bus is released (high impedance), the address bus is 0x0000 and the read-valid output is low.
- R2: The address bus takes the address of every accepted request, whatever its kind, and holds it while no request is accepted. Kind encoding: 2'b00 internal data access, 2'b01 code fetch, 2'b10 data read, 2'b11 data write.
- R3: With the external-access select low, a code fetch at 0x2000 or above drives the program strobe low for exactly one cycle. A fetch below 0x2000 (for example 0x1FFF) asserts no strobe, leaves the bus released and produces no read-valid pulse.
- R4: With the external-access select high, a code fetch at any address, 0x0000 included, drives the program strobe low for one cycle.
- R5: A data read drives the read strobe low for exactly one cycle. The program and write strobes stay high and the data bus stays released.
- R6: A data write drives the write strobe low for exactly one cycle and drives the write byte on the data bus during that cycle only. The program and read strobes stay high.
- R7: For an external read or fetch, read data equals the bus value at the clock edge that ends the access cycle. Read-valid is high for exactly the following cycle. No other request kind raises read-valid.
- R8: The data bus is released whenever no write is in progress and suspend is low, including during internal data accesses.
- R9: While suspend is high the data bus is driven to 0x00, requests are ignored (no strobe, address unchanged), and after suspend falls the bus is released again.
- R10: At most one of the three strobes is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Core presents a request this cycle |
| req_kind | input | 2 | 00 internal data, 01 code fetch, 10 data read, 11 data write |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte for data writes |
| ext_all | input | 1 | External-access select: high sends all code fetches off chip |
| suspend | input | 1 | Suspend indication |
| mem_addr | output | 16 | External address bus |
| mem_data | inout | 8 | External bidirectional data bus |
| pstrobe_n | output | 1 | Active-low program store strobe |
| mem_rd_n | output | 1 | Active-low data read strobe |
| mem_wr_n | output | 1 | Active-low data write strobe |
| rd_data | output | 8 | Captured read byte to the core |
| rd_valid | output | 1 | One-cycle pulse marking new read data |

## Verification
Code fetches are tried on both sides of the 0x2000 boundary (0x1FFF, 0x2000, 0xFFFF) with the select pin low, then at 0x0000 and 0x1FFF with the pin high. This shows whether the decode really moves with the pin and whether the boundary comparison is off by one. Data reads, writes and internal accesses are issued singly and back to back, with an address-dependent memory model on the bus. A stuck or shifted capture, or a strobe held for two cycles, therefore yields a wrong byte or an extra pulse at the scoreboard. Suspend is applied together with a pending write to separate "bus forced low" from "bus driven with write data" and from "request accepted".

// File: rtl/emb_pkg.sv
package emb_pkg;

  // Core-side request kinds (port encoding, see brief R2)
  typedef enum logic [1:0] {
    KIND_INT  = 2'b00,
    KIND_CODE = 2'b01,
    KIND_RD   = 2'b10,
    KIND_WR   = 2'b11
  } req_kind_e;

  // Kind of external cycle that the next clock edge launches
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_CODE = 2'b01,
    ACC_RD   = 2'b10,
    ACC_WR   = 2'b11
  } acc_e;

endpackage

// File: rtl/emb_decode.sv
module emb_decode
  import emb_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int INT_CODE_TOP = 'h2000
) (
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              ext_all,
  input  logic              suspend,
  output logic              take,
  output acc_e              acc_kind
);

  localparam logic [ADDR_W-1:0] CODE_BASE = ADDR_W'(INT_CODE_TOP);

  logic code_off_chip;

  // The internal code window disappears when the select pin is high
  assign code_off_chip = ext_all || (req_addr >= CODE_BASE);

  // Requests arriving during suspend are dropped
  assign take = req_valid && !suspend;

  always_comb begin
    acc_kind = ACC_NONE;
    if (take) begin
      unique case (req_kind_e'(req_kind))
        KIND_CODE: acc_kind = code_off_chip ? ACC_CODE : ACC_NONE;
        KIND_RD:   acc_kind = ACC_RD;
        KIND_WR:   acc_kind = ACC_WR;
        default:   acc_kind = ACC_NONE;
      endcase
    end
  end

endmodule

// File: rtl/emb_cycle_ctl.sv
module emb_cycle_ctl
  import emb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  acc_e              acc_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              suspend,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] wdata,
  output logic              pstrobe_n,
  output logic              rd_n,
  output logic              wr_n
);

  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              psen_q,  psen_d;
  logic              rdn_q,   rdn_d;
  logic              wrn_q,   wrn_d;
  logic              wdata_en;

  assign wdata_en = (acc_kind == ACC_WR);

  // Next-state logic
  always_comb begin
    addr_d  = take     ? req_addr  : addr_q;
    wdata_d = wdata_en ? req_wdata : wdata_q;
    psen_d  = !(acc_kind == ACC_CODE);
    rdn_d   = !(acc_kind == ACC_RD);
    wrn_d   = !(acc_kind == ACC_WR);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      psen_q  <= 1'b1;
      rdn_q   <= 1'b1;
      wrn_q   <= 1'b1;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      psen_q  <= psen_d;
      rdn_q   <= rdn_d;
      wrn_q   <= wrn_d;
    end
  end

  assign mem_addr  = addr_q;
  assign wdata     = wdata_q;
  assign pstrobe_n = psen_q;
  assign rd_n      = rdn_q;
  assign wr_n      = wrn_q;

  // R10: strobes are mutually exclusive
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_q, !rdn_q, !wrn_q}) <= 1);

  // R2: address holds when nothing was accepted
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(mem_addr));

  // R9: a cycle that saw suspend launches no strobe
  a_r9_no_strobe_in_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> (pstrobe_n && rd_n && wr_n));

  // R3: a program strobe only ever follows an accepted request
  a_r3_strobe_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> pstrobe_n);

endmodule

// File: rtl/emb_data_path.sv
module emb_data_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pstrobe_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              suspend,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic              capture;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              vld_q,   vld_d;

  // Bus drive: zeros in suspend, write byte during a write cycle
  assign bus_oe  = suspend || !wr_n;
  assign bus_out = suspend ? '0 : wdata;

  // The access cycle ends at the next edge; sample the bus there
  assign capture = !rd_n || !pstrobe_n;

  always_comb begin
    rdata_d = capture ? bus_in : rdata_q;
    vld_d   = capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      vld_q   <= vld_d;
    end
  end

  assign rd_data  = rdata_q;
  assign rd_valid = vld_q;

  // R7: each read or fetch strobe yields one valid pulse next cycle
  a_r7_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !pstrobe_n) |=> rd_valid);

  // R7: no valid pulse without a preceding read or fetch strobe
  a_r7_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && pstrobe_n) |=> !rd_valid);

  // R5: the bus is never driven during a read or fetch outside suspend
  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_n || !pstrobe_n) && !suspend) |-> !bus_oe);

  // R8: the bus is driven only for a write or in suspend
  a_r8_drive_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!wr_n || suspend));

endmodule

// File: rtl/emb_bus_if.sv
module emb_bus_if
  import emb_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int INT_CODE_TOP = 'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ext_all,
  input  logic              suspend,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_data,
  output logic              pstrobe_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic              take;
  acc_e              acc_kind;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] bus_out;
  logic              bus_oe;

  emb_decode #(
    .ADDR_W       (ADDR_W),
    .INT_CODE_TOP (INT_CODE_TOP)
  ) u_decode (
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .ext_all   (ext_all),
    .suspend   (suspend),
    .take      (take),
    .acc_kind  (acc_kind)
  );

  emb_cycle_ctl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_cycle (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .take      (take),
    .acc_kind  (acc_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .suspend   (suspend),
    .mem_addr  (mem_addr),
    .wdata     (wdata),
    .pstrobe_n (pstrobe_n),
    .rd_n      (mem_rd_n),
    .wr_n      (mem_wr_n)
  );

  emb_data_path #(
    .DATA_W (DATA_W)
  ) u_data (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pstrobe_n (pstrobe_n),
    .rd_n      (mem_rd_n),
    .wr_n      (mem_wr_n),
    .wdata     (wdata),
    .suspend   (suspend),
    .bus_in    (mem_data),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  assign mem_data = bus_oe ? bus_out : {DATA_W{1'bz}};

  // R6: the write byte appears on the bus during the write cycle
  a_r6_write_drives: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mem_wr_n && !suspend) |-> (bus_oe && bus_out == wdata));

endmodule

// File: tb/tb_emb_bus_if.sv
`timescale 1ns/1ps
module tb_emb_bus_if;

  localparam int CLK_HALF = 10;  // 50 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_addr = 16'h0000;
  logic [7:0]  req_wdata = 8'h00;
  logic        ext_all = 1'b0;
  logic        suspend = 1'b0;
  logic [15:0] mem_addr;
  wire  [7:0]  mem_data;
  logic        pstrobe_n, mem_rd_n, mem_wr_n;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int checks = 0;
  int fails  = 0;
  byte unsigned exp_q[$];

  always #CLK_HALF clk = ~clk;

  emb_bus_if dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ext_all   (ext_all),
    .suspend   (suspend),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .pstrobe_n (pstrobe_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  // Memory model: answers reads and fetches; bus pulled high when idle
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_data = (!mem_rd_n || !pstrobe_n) ? mem_byte(mem_addr) : 8'hzz;
  for (genvar b = 0; b < 8; b++) begin : g_pull
    pullup pu (mem_data[b]);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compare every read-valid pulse with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected rd_valid", 32'(rd_data), 32'hFFFF);
      end else begin
        byte unsigned e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R7 read data", 32'(rd_data), 32'(e));
      end
    end
  end

  // Driver: one request; checks the access cycle and that it lasts one cycle
  task automatic do_op(input logic [1:0] kind, input logic [15:0] a,
                       input logic [7:0] wd, input bool_last);
    bit ext_code, exp_p, exp_r, exp_w;
    ext_code = (kind == 2'b01) && (ext_all || a >= 16'h2000);
    exp_p = ext_code;
    exp_r = (kind == 2'b10);
    exp_w = (kind == 2'b11);
    req_valid = 1'b1; req_kind = kind; req_addr = a; req_wdata = wd;
    if (exp_p || exp_r) exp_q.push_back(mem_byte(a));
    @(negedge clk);
    if (bool_last) req_valid = 1'b0;
    chk(mem_addr == a, "R2 address", 32'(mem_addr), 32'(a));
    chk(pstrobe_n == !exp_p, exp_p ? "R3/R4 program strobe low" : "R3 program strobe high",
        32'(pstrobe_n), 32'(!exp_p));
    chk(mem_rd_n == !exp_r, "R5 read strobe", 32'(mem_rd_n), 32'(!exp_r));
    chk(mem_wr_n == !exp_w, "R6 write strobe", 32'(mem_wr_n), 32'(!exp_w));
    if (exp_w)
      chk(mem_data == wd, "R6 bus carries write byte", 32'(mem_data), 32'(wd));
    else if (!exp_p && !exp_r)
      chk(mem_data == 8'hFF, "R8 bus released", 32'(mem_data), 32'hFF);
  endtask

  task automatic idle_check(input string tag);
    chk(pstrobe_n && mem_rd_n && mem_wr_n, {tag, " strobes high after one cycle"},
        32'({pstrobe_n, mem_rd_n, mem_wr_n}), 32'h7);
    chk(mem_data == 8'hFF, {tag, " bus released"}, 32'(mem_data), 32'hFF);
  endtask

  initial begin
    #(CLK_HALF * 2 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pstrobe_n && mem_rd_n && mem_wr_n, "R1 strobes high", 32'({pstrobe_n, mem_rd_n, mem_wr_n}), 32'h7);
    chk(mem_data == 8'hFF, "R1 bus released", 32'(mem_data), 32'hFF);
    chk(mem_addr == 16'h0000, "R1 address zero", 32'(mem_addr), 32'h0);
    chk(rd_valid == 1'b0, "R1 no read valid", 32'(rd_valid), 32'h0);

    // R3: select low, both sides of the boundary
    ext_all = 1'b0;
    do_op(2'b01, 16'h1FFF, 8'h00, 1'b1); @(negedge clk); idle_check("R3");
    chk(rd_valid == 1'b0, "R3 internal fetch no valid", 32'(rd_valid), 32'h0);
    do_op(2'b01, 16'h2000, 8'h00, 1'b1); @(negedge clk); idle_check("R3");
    do_op(2'b01, 16'hFFFF, 8'h00, 1'b1); @(negedge clk); idle_check("R3");

    // R4: select high, whole space off chip
    ext_all = 1'b1;
    do_op(2'b01, 16'h0000, 8'h00, 1'b1); @(negedge clk); idle_check("R4");
    do_op(2'b01, 16'h1FFF, 8'h00, 1'b1); @(negedge clk); idle_check("R4");
    ext_all = 1'b0;

    // R5 / R6 / R8 single accesses
    do_op(2'b10, 16'h4321, 8'h00, 1'b1); @(negedge clk); idle_check("R5");
    do_op(2'b11, 16'h8001, 8'hA5, 1'b1); @(negedge clk); idle_check("R6");
    do_op(2'b00, 16'h0042, 8'h00, 1'b1); @(negedge clk); idle_check("R8");
    chk(mem_addr == 16'h0042, "R2 internal address held", 32'(mem_addr), 32'h42);

    // Back to back: read, write, fetch, read (R7 ordering, R10)
    do_op(2'b10, 16'h1111, 8'h00, 1'b0);
    do_op(2'b11, 16'h2222, 8'h3C, 1'b0);
    do_op(2'b01, 16'h3333, 8'h00, 1'b0);
    do_op(2'b10, 16'h00F0, 8'h00, 1'b1);
    @(negedge clk); idle_check("R7");
    @(negedge clk);
    chk(rd_valid == 1'b0, "R7 valid is one pulse", 32'(rd_valid), 32'h0);

    // R9 suspend with a pending write request
    held = mem_addr;
    suspend = 1'b1;
    req_valid = 1'b1; req_kind = 2'b11; req_addr = 16'h1234; req_wdata = 8'hEE;
    @(negedge clk);
    chk(mem_data == 8'h00, "R9 bus driven low", 32'(mem_data), 32'h0);
    chk(mem_wr_n && pstrobe_n && mem_rd_n, "R9 no strobe", 32'({pstrobe_n, mem_rd_n, mem_wr_n}), 32'h7);
    chk(mem_addr == held, "R9 address unchanged", 32'(mem_addr), 32'(held));
    req_valid = 1'b0;
    suspend = 1'b0;
    @(negedge clk);
    chk(mem_data == 8'hFF, "R9 bus released after suspend", 32'(mem_data), 32'hFF);
    chk(mem_addr == held, "R9 address still unchanged", 32'(mem_addr), 32'(held));
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all reads returned", 32'(exp_q.size()), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule